// File: doc/BRIEF.md
# Synchronous Serial Master with Transfer Status Flags

This block drives a synchronous serial bus as the clock master. A host writes characters of 1 to 16 bits into a one-deep transmit holding register. A character is shifted out on `mosi` while the same number of bits are shifted in from `miso`, timed by a serial clock `sclk`. A free-running divider makes half-bit ticks from the system clock. The idle level of `sclk` and the edge on which data is latched are set by two mode inputs. Bit order is also selectable.

Three status outputs report progress, each timed exactly against the half-bit ticks. `busy` covers the whole time a character is on the wire. `tx_empty_req` is a one-cycle request that tells the host the holding register can take another character. `rx_done_req` is a one-cycle request that marks a newly received character on `rx_data`. Characters written while one is shifting follow it back to back, with no gap on `sclk`.

Top module: `spim_master`

## Requirements
- R1: After a write to an idle block, `busy` stays low in the cycle after the write and rises at the next half-bit tick, between 1 and `cfg_reload`+1 cycles after the write was sampled. A half-bit tick occurs once every `cfg_reload`+1 system clocks.
- R2: A write while nothing is shifting or waiting to start makes `tx_empty_req` high for exactly one cycle, visible in the cycle right after the write.
- R3: A write while a character is shifting goes to the holding register and raises no immediate request. `tx_empty_req` then pulses in the same cycle as that character's `rx_done_req`, at its last latching edge. The held character follows with `busy` staying high and no missing `sclk` edge.
- R4: `rx_done_req` is high for exactly one cycle per character, and `rx_data` holds the new character in that same cycle. Bit positions at and above the character length read 0.
- R5: `busy` falls exactly `cfg_reload`+1 cycles (half a bit) after the cycle in which `rx_done_req` is seen, unless another character follows.
- R6: `mosi` is sampled by the far end, and `miso` by the block, on the latching edge of `sclk`. That edge is falling when `cfg_cpol` equals `cfg_cpha`, and rising otherwise.
- R7: `sclk` rests at the level of `cfg_cpol` while idle. During a transfer it toggles only on half-bit ticks, giving exactly 2×length edges per character.
- R8: With `cfg_lsb_first`=1, bit 0 of a character goes first. With `cfg_lsb_first`=0, bit length-1 goes first. The same order applies to sending and receiving.
- R9: The character length is `cfg_len_m1`+1 bits, for any value from 1 to 16. Transmit bits above the length are never driven out.
- R10: Reset clears `busy`, both requests and `rx_data` to 0 and abandons any transfer in progress. `sclk` is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_reload | input | DIV_W | Half-bit divider reload; one half bit lasts cfg_reload+1 clocks |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | Phase select; with cfg_cpol it sets the latching edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant first |
| cfg_len_m1 | input | LEN_W | Character length minus one |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | MAX_LEN | Character to send |
| rx_data | output | MAX_LEN | Last character received |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A character is on the wire |
| tx_empty_req | output | 1 | One-cycle request: holding register free |
| rx_done_req | output | 1 | One-cycle request: character received |

## Verification
The bench builds the block with a 16-bit maximum character and a 4-bit divider. This covers both the 1-bit and the full 16-bit character, and keeps each run of half-bit ticks to a few cycles. Divider reloads of 0 to 3 are used. With reload 0 a tick occurs every cycle, which puts the last latching edge, the end tick and the back-to-back hand-off on adjacent cycles. With reload 3 the up-to-half-bit delay before `busy` rises is clearly visible. All four polarity and phase combinations and both bit orders are driven against a slave model that samples on the edge required by R6.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    bit_order_e order;
  } spim_mode_t;

  // Phase bit set: the first sclk edge of a character is a latching edge.
  function automatic logic latch_on_lead(input spim_mode_t m);
    return m.cpha;
  endfunction

  // Latching happens on the falling sclk edge when polarity equals phase.
  function automatic logic latch_on_fall(input spim_mode_t m);
    return m.cpol == m.cpha;
  endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= reload;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/spim_seq.sv
module spim_seq
  import spim_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN),
  localparam int IDX_W = $clog2(2*MAX_LEN+2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  spim_mode_t       mode,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             start_ev,
  input  logic             chain,
  output logic             act,
  output logic             sclk,
  output logic             latch_ev,
  output logic             last_latch,
  output logic             adv_ev,
  output logic             end_ev
);
  // Number of sclk edges in one character.
  function automatic logic [IDX_W-1:0] edge_total(input logic [LEN_W-1:0] lm1);
    logic [IDX_W-1:0] n;
    n = IDX_W'(lm1) + IDX_W'(1);
    return n << 1;
  endfunction

  logic [IDX_W-1:0] idx, cur, two_n, end_idx;
  logic             lead, toggle, on_tick;

  assign lead    = latch_on_lead(mode);
  assign two_n   = edge_total(len_m1);
  assign end_idx = two_n + IDX_W'(!lead);
  assign cur     = idx + IDX_W'(1);
  assign on_tick = act && tick;

  assign toggle     = on_tick && (cur <= two_n);
  assign latch_ev   = toggle && (cur[0] == lead);
  assign last_latch = latch_ev && (cur == end_idx - IDX_W'(1));
  assign adv_ev     = on_tick && (cur >= IDX_W'(2)) && (cur < end_idx) && (cur[0] != lead);
  assign end_ev     = on_tick && (cur == end_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else if (start_ev) begin
      act <= 1'b1;
      idx <= '0;
    end else if (end_ev) begin
      act <= chain;
      idx <= '0;
    end else if (on_tick) begin
      idx <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sclk <= 1'b0;
    else if (toggle) sclk <= ~sclk;
    else if (!act)   sclk <= mode.cpol;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bit_order_e         order,
  input  logic [LEN_W-1:0]   len_m1,
  input  logic               sr_load,
  input  logic [MAX_LEN-1:0] sr_data,
  input  logic               cnt_clr,
  input  logic               adv_ev,
  input  logic               latch_ev,
  input  logic               last_latch,
  input  logic               miso,
  output logic               mosi,
  output logic [MAX_LEN-1:0] rx_data
);
  // Position in the character of the k-th bit on the wire.
  function automatic logic [LEN_W-1:0] wire_pos(input bit_order_e o,
                                                input logic [LEN_W-1:0] lm1,
                                                input logic [LEN_W-1:0] k);
    return (o == ORDER_LSB) ? k : lm1 - k;
  endfunction

  logic [MAX_LEN-1:0] tx_sr, rx_sr, rx_next;
  logic [LEN_W-1:0]   tcnt, rcnt;

  assign mosi    = tx_sr[wire_pos(order, len_m1, tcnt)];
  assign rx_next = rx_sr | ({{(MAX_LEN-1){1'b0}}, miso} << wire_pos(order, len_m1, rcnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      tcnt    <= '0;
      rx_sr   <= '0;
      rcnt    <= '0;
      rx_data <= '0;
    end else begin
      if (sr_load) tx_sr <= sr_data;
      if (cnt_clr)     tcnt <= '0;
      else if (adv_ev) tcnt <= tcnt + 1'b1;
      if (cnt_clr) begin
        rx_sr <= '0;
        rcnt  <= '0;
      end else if (latch_ev) begin
        rx_sr <= rx_next;
        rcnt  <= rcnt + 1'b1;
      end
      if (last_latch) rx_data <= rx_next;
    end
  end
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_reload,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [LEN_W-1:0]   cfg_len_m1,
  input  logic               tx_wr,
  input  logic [MAX_LEN-1:0] tx_data,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               busy,
  output logic               tx_empty_req,
  output logic               rx_done_req
);
  spim_mode_t mode;
  assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha, order: bit_order_e'(cfg_lsb_first)};

  // Named internal events, also used by the checker.
  logic tick, act, start_ev, end_ev, latch_ev, last_latch, adv_ev;
  logic direct_wr, idle_kick, handoff, chain, chain_from_buf, sr_load;
  logic pend, tbuf_full, nxt_vld;
  logic [MAX_LEN-1:0] tbuf, nxt, sr_data;

  assign direct_wr      = tx_wr && !act && !pend && !tbuf_full;
  assign idle_kick      = !act && !pend && tbuf_full;
  assign start_ev       = pend && !act && tick;
  assign handoff        = last_latch && tbuf_full;
  assign chain          = end_ev && (nxt_vld || tbuf_full);
  assign chain_from_buf = end_ev && !nxt_vld && tbuf_full;
  assign sr_load        = direct_wr || idle_kick || chain;
  assign sr_data        = chain     ? (nxt_vld ? nxt : tbuf) :
                          direct_wr ? tx_data : tbuf;

  spim_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .reload(cfg_reload), .tick(tick)
  );

  spim_seq #(.MAX_LEN(MAX_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .len_m1(cfg_len_m1),
    .start_ev(start_ev), .chain(chain), .act(act), .sclk(sclk),
    .latch_ev(latch_ev), .last_latch(last_latch), .adv_ev(adv_ev), .end_ev(end_ev)
  );

  spim_shift #(.MAX_LEN(MAX_LEN)) shift_i (
    .clk(clk), .rst_n(rst_n), .order(mode.order), .len_m1(cfg_len_m1),
    .sr_load(sr_load), .sr_data(sr_data), .cnt_clr(sr_load || start_ev),
    .adv_ev(adv_ev), .latch_ev(latch_ev), .last_latch(last_latch),
    .miso(miso), .mosi(mosi), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend         <= 1'b0;
      tbuf_full    <= 1'b0;
      tbuf         <= '0;
      nxt_vld      <= 1'b0;
      nxt          <= '0;
      tx_empty_req <= 1'b0;
      rx_done_req  <= 1'b0;
    end else begin
      if (direct_wr || idle_kick) pend <= 1'b1;
      else if (start_ev)          pend <= 1'b0;

      if (tx_wr && !direct_wr) begin
        tbuf      <= tx_data;
        tbuf_full <= 1'b1;
      end else if (handoff || chain_from_buf || idle_kick) begin
        tbuf_full <= 1'b0;
      end

      if (handoff) begin
        nxt     <= tbuf;
        nxt_vld <= 1'b1;
      end else if (end_ev) begin
        nxt_vld <= 1'b0;
      end

      tx_empty_req <= direct_wr || idle_kick || handoff || chain_from_buf;
      rx_done_req  <= last_latch;
    end
  end

  assign busy = act;
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sclk,
  input logic tick,
  input logic end_ev,
  input logic tx_empty_req,
  input logic rx_done_req
);
  assert_busy_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  assert_txe_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_req |=> !tx_empty_req);

  assert_rx_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_req |=> !rx_done_req);

  assert_rx_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_req |-> busy);

  assert_busy_fall_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(tick) && $past(end_ev)));

  assert_sclk_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sclk)) |-> $past(tick));
endmodule

bind spim_master spim_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .tick(tick),
  .end_ev(end_ev), .tx_empty_req(tx_empty_req), .rx_done_req(rx_done_req)
);

// File: tb/spim_master_tb.sv
`timescale 1ns/1ps
module spim_master_tb_top;
  localparam int MAX_LEN = 16;
  localparam int DIV_W   = 4;
  localparam int LEN_W   = $clog2(MAX_LEN);

  typedef struct packed {
    logic [3:0]  rl;
    logic        pol;
    logic        pha;
    logic        lsb;
    logic [3:0]  lm1;
    logic [15:0] tx;
    logic [15:0] sl;
    logic [15:0] exp_mosi;
    logic [15:0] exp_rx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'd7,  16'h00A5, 16'h003C, 16'h00A5, 16'h003C},
    '{4'd0, 1'b0, 1'b1, 1'b1, 4'd7,  16'h0081, 16'h0042, 16'h0081, 16'h0042},
    '{4'd2, 1'b1, 1'b0, 1'b0, 4'd15, 16'hBEEF, 16'h1234, 16'hBEEF, 16'h1234},
    '{4'd3, 1'b1, 1'b1, 1'b1, 4'd4,  16'h00F3, 16'h00FA, 16'h0013, 16'h001A},
    '{4'd1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0001, 16'h0001, 16'h0001, 16'h0001},
    '{4'd0, 1'b1, 1'b1, 1'b0, 4'd11, 16'hFABC, 16'h0F0F, 16'h0ABC, 16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0]   cfg_reload = '0;
  logic               cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [LEN_W-1:0]   cfg_len_m1 = '0;
  logic               tx_wr = 1'b0;
  logic [MAX_LEN-1:0] tx_data = '0;
  logic [MAX_LEN-1:0] rx_data;
  logic               sclk, mosi, busy, tx_empty_req, rx_done_req;
  logic               miso = 1'b0;

  always #2.5 clk = ~clk;

  spim_master #(.MAX_LEN(MAX_LEN), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_len_m1(cfg_len_m1),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .busy(busy), .tx_empty_req(tx_empty_req), .rx_done_req(rx_done_req)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  // Slave model settings (written by stimulus only).
  int          arm_seq = 0;
  logic [15:0] mon_sl = '0;
  int          mon_nb = 1;
  logic        mon_lsb = 1'b0;
  logic        mon_fall = 1'b1;

  // Slave model results (written by the monitor only).
  int          seen_seq = 0;
  int          lat_cnt = 0, edges = 0, n_mosi = 0, n_rx = 0, falls = 0;
  int          since_rx = -1, fall_dly = -1;
  logic [15:0] macc = '0;
  logic [15:0] obs_mosi [0:3];
  logic [15:0] obs_rx [0:3];
  logic        obs_txe [0:3];
  logic        prev_sclk = 1'b0, prev_busy = 1'b0;

  function automatic int bpos(input logic lsb, input int nb, input int k);
    return lsb ? k : nb - 1 - k;
  endfunction

  always @(negedge clk) begin
    if (arm_seq != seen_seq) begin
      seen_seq = arm_seq;
      lat_cnt = 0; edges = 0; n_mosi = 0; n_rx = 0; falls = 0;
      since_rx = -1; fall_dly = -1; macc = '0;
    end else begin
      if (sclk !== prev_sclk) begin
        edges++;
        if ((sclk == 1'b0) == mon_fall) begin
          macc[bpos(mon_lsb, mon_nb, lat_cnt)] = mosi;
          lat_cnt++;
          if (lat_cnt == mon_nb) begin
            if (n_mosi < 4) obs_mosi[n_mosi] = macc;
            n_mosi++;
            lat_cnt = 0;
            macc = '0;
          end
        end
      end
      if (prev_busy && !busy) falls++;
      if (rx_done_req) begin
        if (n_rx < 4) begin
          obs_rx[n_rx]  = rx_data;
          obs_txe[n_rx] = tx_empty_req;
        end
        n_rx++;
        since_rx = 0;
      end else if (since_rx >= 0) begin
        since_rx++;
        if (!busy && fall_dly < 0) fall_dly = since_rx;
      end
    end
    prev_sclk = sclk;
    prev_busy = busy;
    miso = mon_sl[bpos(mon_lsb, mon_nb, lat_cnt)];
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic setup(input vec_t v);
    cfg_reload    = v.rl;
    cfg_cpol      = v.pol;
    cfg_cpha      = v.pha;
    cfg_lsb_first = v.lsb;
    cfg_len_m1    = v.lm1;
    mon_sl        = v.sl;
    mon_nb        = int'(v.lm1) + 1;
    mon_lsb       = v.lsb;
    mon_fall      = (v.pol == v.pha);
    arm_seq++;
    step();
    step();
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin step(); n++; end
    step();
  endtask

  task automatic run_vec(input vec_t v, input int id);
    int wn;
    setup(v);
    chk("R7", $sformatf("v%0d sclk idle level", id), sclk, v.pol);
    tx_data = v.tx;
    tx_wr = 1'b1;
    step();
    tx_wr = 1'b0;
    chk("R1", $sformatf("v%0d busy low after write", id), busy, 1'b0);
    chk("R2", $sformatf("v%0d immediate empty request", id), tx_empty_req, 1'b1);
    wn = 0;
    while (!busy && wn < 100) begin step(); wn++; end
    chk("R1", $sformatf("v%0d busy delay within tick", id),
        (wn >= 1 && wn <= int'(v.rl) + 1), 1'b1);
    wait_idle();
    chk("R6", $sformatf("v%0d mosi word count", id), n_mosi, 1);
    chk("R8", $sformatf("v%0d mosi word", id), obs_mosi[0], v.exp_mosi);
    chk("R4", $sformatf("v%0d rx pulse count", id), n_rx, 1);
    chk("R9", $sformatf("v%0d rx word", id), obs_rx[0], v.exp_rx);
    chk("R5", $sformatf("v%0d busy clear delay", id), fall_dly, int'(v.rl) + 1);
    chk("R7", $sformatf("v%0d sclk edge count", id), edges, 2 * (int'(v.lm1) + 1));
    chk("R7", $sformatf("v%0d sclk back to idle", id), sclk, v.pol);
  endtask

  initial begin
    vec_t bb;
    vec_t rv;
    step();
    step();
    chk("R10", "busy in reset", busy, 1'b0);
    chk("R10", "sclk in reset", sclk, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R10", "busy after reset", busy, 1'b0);
    chk("R10", "rx_data after reset", rx_data, 16'h0000);
    chk("R10", "tx_empty_req after reset", tx_empty_req, 1'b0);
    chk("R10", "rx_done_req after reset", rx_done_req, 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // Back-to-back characters through the holding register.
    bb = '{4'd1, 1'b0, 1'b1, 1'b0, 4'd3, 16'h0009, 16'h0005, 16'h0009, 16'h0005};
    setup(bb);
    tx_data = 16'h0009;
    tx_wr = 1'b1;
    step();
    tx_data = 16'h0006;
    chk("R2", "first write immediate request", tx_empty_req, 1'b1);
    step();
    tx_wr = 1'b0;
    chk("R3", "buffered write has no immediate request", tx_empty_req, 1'b0);
    step();
    while (n_rx < 1) step();
    wait_idle();
    chk("R3", "two characters sent", n_mosi, 2);
    chk("R3", "first character", obs_mosi[0], 16'h0009);
    chk("R3", "second character", obs_mosi[1], 16'h0006);
    chk("R3", "empty request with first rx", obs_txe[0], 1'b1);
    chk("R3", "no request with second rx", obs_txe[1], 1'b0);
    chk("R3", "busy dropped once", falls, 1);
    chk("R3", "edges without gap", edges, 16);
    chk("R4", "second rx word", obs_rx[1], 16'h0005);

    // Reset in the middle of a long character.
    rv = '{4'd3, 1'b0, 1'b0, 1'b1, 4'd15, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    setup(rv);
    tx_data = 16'hFFFF;
    tx_wr = 1'b1;
    step();
    tx_wr = 1'b0;
    for (int k = 0; k < 20; k++) step();
    chk("R10", "busy mid transfer", busy, 1'b1);
    rst_n = 1'b0;
    step();
    chk("R10", "busy cleared by reset", busy, 1'b0);
    chk("R10", "rx_data cleared by reset", rx_data, 16'h0000);
    chk("R10", "sclk low in reset", sclk, 1'b0);
    rst_n = 1'b1;
    step();
    for (int k = 0; k < 10; k++) step();
    chk("R10", "stays idle after reset", busy, 1'b0);
    run_vec(VEC[0], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule